// File: doc/BRIEF.md
# Sync Polarity and Presence Detector

This block watches two already-sampled one-bit sync streams. One is the horizontal or composite channel and the other is the vertical channel. For each stream it decides whether a sync signal is present at all, and if it is, whether the pulses go high from a low idle level or go low from a high idle level. Every channel drives a state flag and a polarity flag for the display controller that chooses the sync path.

Each channel counts its samples over a fixed window of clock cycles. A low sample adds one and a high sample subtracts one. The sum at the end of the window is the low-time excess, a digital stand-in for a filtered DC level compared against a band on either side of the midpoint. If the input has held one level long enough, the channel reports no input whatever that level is. A result reaches the flags only after two windows in a row agree, which stops the flags chattering.

The two channels use the same logic. Each has its own window length, threshold and timeout, because the vertical rate needs a much longer window than the horizontal rate.

Top module: `sync_polarity_detect`

## Requirements
- R1: After reset all four flags are low, and they stay low until two complete windows of a channel have agreed on a positive or negative result.
- R2: Within a window each low sample counts +1 and each high sample counts −1. A window whose sum is at least +THR, with an edge seen recently, classifies as positive. This includes a sum of exactly +THR.
- R3: A window whose sum is at most −THR, with an edge seen recently, classifies as negative. This includes a sum of exactly −THR.
- R4: A window whose sum lies strictly between −THR and +THR classifies as no input. A 50% duty square wave is one such case.
- R5: If no level change has been seen for TMO consecutive samples when a window ends, that window classifies as no input, whatever the static level is.
- R6: The flags change only when a window ends with the same class as the window just before it. A single window that differs leaves the flags unchanged.
- R7: The state flag is 1 for a positive or negative committed result and 0 for no input.
- R8: The polarity flag is 1 only for a negative committed result. It is 0 for positive and for no input, so it is never 1 while the state flag is 0.
- R9: The horizontal and vertical channels classify independently, each with its own window length, threshold and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_smp_i | input | 1 | Sampled horizontal/composite sync level |
| vsync_smp_i | input | 1 | Sampled vertical sync level |
| h_state_o | output | 1 | Horizontal channel: sync present |
| h_pol_o | output | 1 | Horizontal channel: negative-going pulses |
| v_state_o | output | 1 | Vertical channel: sync present |
| v_pol_o | output | 1 | Vertical channel: negative-going pulses |

## Verification
The bench builds the block with a horizontal window of 64 samples, a threshold of 16 and a timeout of 48. The vertical channel uses a window of 256, a threshold of 64 and a timeout of 192. With these values a period-8 pulse train fits a whole number of times into both windows. Three high samples out of eight then land exactly on +THR in both channels, and five out of eight land exactly on −THR. This puts the inclusive threshold boundaries, the static-level timeout and the single-window glitch within a few hundred cycles. Because the windows differ, the two channels can be driven to different classes at the same moment.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_POS  = 2'd1,
        CLS_NEG  = 2'd2
    } sync_cls_e;

endpackage

// File: rtl/syncdet_window.sv
module syncdet_window
    import syncdet_pkg::*;
#(
    parameter int WIN = 1024,
    parameter int THR = 256,
    parameter int TMO = 768
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_i,
    output logic      done_o,
    output sync_cls_e res_o
);

    localparam int CNT_W  = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int ACC_W  = $clog2(WIN + 1) + 2;
    localparam int IDLE_W = $clog2(TMO + 1);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(WIN - 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TMO);

    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic signed [ACC_W-1:0]  acc;
        logic [IDLE_W-1:0]        idle;
        logic                     prev;
        logic                     prev_vld;
        logic                     done;
        sync_cls_e                res;
    } win_state_t;

    win_state_t st_d, st_q;

    logic                    edge_seen;
    logic signed [ACC_W-1:0] acc_step;
    logic signed [ACC_W-1:0] acc_sum;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        edge_seen     = st_q.prev_vld && (smp_i != st_q.prev);
        st_d.prev     = smp_i;
        st_d.prev_vld = 1'b1;

        if (edge_seen) begin
            st_d.idle = '0;
        end else if (st_q.idle != IDLE_MAX) begin
            st_d.idle = st_q.idle + IDLE_W'(1);
        end

        acc_step = smp_i ? -ACC_W'(1) : ACC_W'(1);
        acc_sum  = st_q.acc + acc_step;

        if (st_q.cnt == LAST_CNT) begin
            st_d.cnt  = '0;
            st_d.acc  = '0;
            st_d.done = 1'b1;
            if (st_d.idle == IDLE_MAX) begin
                st_d.res = CLS_NONE;
            end else if (acc_sum >= ACC_W'(THR)) begin
                st_d.res = CLS_POS;
            end else if (acc_sum <= -ACC_W'(THR)) begin
                st_d.res = CLS_NEG;
            end else begin
                st_d.res = CLS_NONE;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.acc = acc_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.acc      <= '0;
            st_q.idle     <= IDLE_MAX;
            st_q.prev     <= 1'b0;
            st_q.prev_vld <= 1'b0;
            st_q.done     <= 1'b0;
            st_q.res      <= CLS_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign res_o  = st_q.res;

    AST_DONE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R2

    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.cnt == '0 && st_q.acc == '0)); // R2

    AST_IDLE_FORCES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.idle == IDLE_MAX) |-> (st_q.res == CLS_NONE)); // R5

endmodule

// File: rtl/syncdet_confirm.sv
module syncdet_confirm
    import syncdet_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      done_i,
    input  sync_cls_e res_i,
    output logic      state_o,
    output logic      pol_o
);

    typedef struct packed {
        sync_cls_e last;
        sync_cls_e cls;
    } cfm_state_t;

    cfm_state_t cf_d, cf_q;

    always_comb begin
        cf_d = cf_q;
        if (done_i) begin
            cf_d.last = res_i;
            if (res_i == cf_q.last) begin
                cf_d.cls = res_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q.last <= CLS_NONE;
            cf_q.cls  <= CLS_NONE;
        end else begin
            cf_q <= cf_d;
        end
    end

    assign state_o = (cf_q.cls != CLS_NONE);
    assign pol_o   = (cf_q.cls == CLS_NEG);

    AST_HOLD_BETWEEN_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(cf_q.cls)); // R6

    AST_NEED_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && res_i != cf_q.last) |=> $stable(cf_q.cls)); // R6

endmodule

// File: rtl/sync_polarity_detect.sv
module sync_polarity_detect
    import syncdet_pkg::*;
#(
    parameter int H_WIN = 1024,
    parameter int H_THR = 256,
    parameter int H_TMO = 768,
    parameter int V_WIN = 65536,
    parameter int V_THR = 16384,
    parameter int V_TMO = 49152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_smp_i,
    input  logic vsync_smp_i,
    output logic h_state_o,
    output logic h_pol_o,
    output logic v_state_o,
    output logic v_pol_o
);

    localparam int NCH = 2;

    logic [NCH-1:0] smp;
    logic [NCH-1:0] state;
    logic [NCH-1:0] pol;

    assign smp = {vsync_smp_i, hsync_smp_i};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam int C_WIN = (ch == 0) ? H_WIN : V_WIN;
        localparam int C_THR = (ch == 0) ? H_THR : V_THR;
        localparam int C_TMO = (ch == 0) ? H_TMO : V_TMO;

        logic      win_done;
        sync_cls_e win_res;

        syncdet_window #(
            .WIN (C_WIN),
            .THR (C_THR),
            .TMO (C_TMO)
        ) i_window (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (smp[ch]),
            .done_o (win_done),
            .res_o  (win_res)
        );

        syncdet_confirm i_confirm (
            .clk     (clk),
            .rst_n   (rst_n),
            .done_i  (win_done),
            .res_i   (win_res),
            .state_o (state[ch]),
            .pol_o   (pol[ch])
        );

        AST_POL_NEEDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            pol[ch] |-> state[ch]); // R8
    end

    assign h_state_o = state[0];
    assign h_pol_o   = pol[0];
    assign v_state_o = state[1];
    assign v_pol_o   = pol[1];

endmodule

// File: tb/test_sync_polarity_detect.sv
`timescale 1ns/1ps
module test_sync_polarity_detect;

    localparam int HW = 64, HT = 16, HO = 48;
    localparam int VW = 256, VT = 64, VO = 192;
    localparam int HOLD = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_in = 1'b0, v_in = 1'b0;
    logic h_st, h_pl, v_st, v_pl;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    int h_hi = 0, v_hi = 0;

    always #2.5 clk = ~clk;

    sync_polarity_detect #(
        .H_WIN(HW), .H_THR(HT), .H_TMO(HO),
        .V_WIN(VW), .V_THR(VT), .V_TMO(VO)
    ) i_sync_polarity_detect (
        .clk(clk), .rst_n(rst_n),
        .hsync_smp_i(h_in), .vsync_smp_i(v_in),
        .h_state_o(h_st), .h_pol_o(h_pl),
        .v_state_o(v_st), .v_pol_o(v_pl)
    );

    // Vector: {high samples per 8 on H, on V, expected {h_st,h_pol,v_st,v_pol}}
    localparam logic [11:0] VEC [0:7] = '{
        {4'd1, 4'd7, 4'b1011},
        {4'd7, 4'd1, 4'b1110},
        {4'd4, 4'd4, 4'b0000},
        {4'd3, 4'd5, 4'b1011},
        {4'd5, 4'd3, 4'b1110},
        {4'd0, 4'd8, 4'b0000},
        {4'd8, 4'd0, 4'b0000},
        {4'd4, 4'd1, 4'b0010}
    };

    task automatic drive_step();
        h_in = ((ph % 8) < h_hi);
        v_in = ((ph % 8) < v_hi);
        @(posedge clk);
        #1;
        ph++;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags actual %b expected %b at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        h_in = 1'b0; v_in = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        ph = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset", {h_st, h_pl, v_st, v_pl}, 4'b0000);

        // Table walk: each pattern held long enough for two pure windows per channel
        for (int i = 0; i < 8; i++) begin
            h_hi = int'(VEC[i][11:8]);
            v_hi = int'(VEC[i][7:4]);
            for (int s = 0; s < HOLD; s++) drive_step();
            chk($sformatf("R2 R3 R4 R5 R7 R8 R9 vec%0d", i),
                {h_st, h_pl, v_st, v_pl}, VEC[i][3:0]);
        end

        // Directed: window-aligned sequence on H, V held at 50% duty
        do_reset();
        v_hi = 4;
        for (int s = 1; s <= 6 * HW; s++) begin
            int w;
            w = (s - 1) / HW;
            h_hi = (w == 3) ? 1 : 7;
            drive_step();
            if (s == HW + HW / 2)
                chk("R1 R6 one window only", {h_st, h_pl, v_st, v_pl}, 4'b0000);
            if (s == 3 * HW + HW / 2)
                chk("R3 R6 negative committed", {h_st, h_pl, v_st, v_pl}, 4'b1100);
            if (s == 4 * HW + HW / 2)
                chk("R6 single positive window ignored", {h_st, h_pl, v_st, v_pl}, 4'b1100);
            if (s == 6 * HW)
                chk("R9 vertical unaffected", {v_st, v_pl}, 2'b00);
        end

        // Reset in the middle of a committed state clears the flags
        do_reset();
        chk("R1 reset after activity", {h_st, h_pl, v_st, v_pl}, 4'b0000);

        // Positive on H reaches flags only after two windows
        h_hi = 1; v_hi = 0;
        for (int s = 1; s <= 3 * HW; s++) begin
            drive_step();
            if (s == HW + HW / 2)
                chk("R6 positive waits", {h_st, h_pl}, 2'b00);
        end
        chk("R2 R7 R8 positive committed", {h_st, h_pl, v_st, v_pl}, 4'b1000);

        // Square wave drops back to none after two windows
        h_hi = 4;
        for (int s = 0; s < 4 * HW; s++) drive_step();
        chk("R4 R7 square wave none", {h_st, h_pl}, 2'b00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule